// File: doc/BRIEF.md
# Stereo Peak-Hold Meter with Serial Readout

This block watches a stream of 16-bit two's-complement PCM samples that alternate between a left and a right channel. For each channel it keeps an 8-bit peak: the top bits of the largest absolute sample magnitude seen since the last readout. A host reads both peaks over a three-wire serial port made of a latch strobe, a serial clock and a data output. The latch strobe copies both peaks into a 16-bit shift register. The host then clocks the bits out, sampling on each rising serial clock edge, while the block advances the data on each falling edge.

Peak capture and readout must not interfere with each other. A retriggerable idle timer watches the serial clock. Every edge reloads the timer, and peak capture stays frozen until the serial clock has been quiet for a programmable number of system clock cycles. A complete 16-clock readout clears both peaks, so each value read covers the interval since the previous full readout. When the host enters metering mode, it should perform one throw-away readout to clear stale contents. Samples that arrive from hold or interpolation stages upstream count as ordinary samples.

Top module: `peak_meter_serial`

## Requirements
- R1: A sample's magnitude is its absolute value, with 0x8000 saturating to 0x7FFF. The 8-bit value compared is magnitude bits [14:7], so 0x8000 gives 0xFF and 0xFF80 gives 0x01.
- R2: On a cycle with `smp_valid` high, the channel picked by `smp_right` (0 = left, 1 = right) takes the sample's 8-bit value only if it is strictly greater than the value held. The other channel is unchanged.
- R3: A rising edge of `ser_latch` loads the shift register with the left peak in bits [7:0] and the right peak in bits [15:8]. `ser_dout` presents bit 0 first, and each falling edge of `ser_clk` advances it by one bit. Over 16 clocks the order is left bits 0..7, then right bits 0..7.
- R4: On the 16th rising `ser_clk` edge of a readout, both peaks clear to zero.
- R5: Every `ser_clk` edge, rising or falling, restarts an idle timer of `IDLE_CYCLES` system clocks. No sample is captured while the timer runs, and capture resumes once it has expired.
- R6: If the idle timer expires after fewer than 16 rising edges of a readout, the rising-edge count returns to zero and the peaks are kept.
- R7: While `meter_en` is low, samples are ignored and the peaks keep their values.
- R8: After reset, both peaks and `ser_dout` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meter_en | input | 1 | Enables peak capture |
| smp_valid | input | 1 | Sample strobe |
| smp_right | input | 1 | Channel of the sample: 0 left, 1 right |
| smp_data | input | 16 | Two's-complement PCM sample |
| ser_clk | input | 1 | Host serial clock, asynchronous |
| ser_latch | input | 1 | Host latch strobe, asynchronous |
| ser_dout | output | 1 | Serial peak data |

## Verification
The hardest state to reach from the ports is a readout cut short: a partial run of serial clocks followed by timer expiry. The stimulus sends eight clocks, waits out the idle window, and then performs two full readouts. The first shows the peak survived. The second shows it was cleared only once a fresh, complete 16-clock sequence had been counted. The capture freeze is reached by sending a sample a few cycles after a lone serial clock pulse, while the timer is still running. A later readout confirms that the sample left no trace.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int SMP_W  = 16;
  localparam int PEAK_W = 8;
  localparam int NCH    = 2;

  // Absolute value with saturation of the most negative code.
  function automatic logic [SMP_W-1:0] sat_abs(input logic [SMP_W-1:0] x);
    logic [SMP_W-1:0] r;
    if (!x[SMP_W-1])
      r = x;
    else if (x == {1'b1, {(SMP_W-1){1'b0}}})
      r = {1'b0, {(SMP_W-1){1'b1}}};
    else
      r = (~x) + 1'b1;
    return r;
  endfunction

  // Top bits of the magnitude below the (always clear) sign position.
  function automatic logic [PEAK_W-1:0] peak_code(input logic [SMP_W-1:0] x);
    logic [SMP_W-1:0] m;
    m = sat_abs(x);
    return m[SMP_W-2 -: PEAK_W];
  endfunction
endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
  parameter int IDLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic busy,
  output logic expire
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(IDLE_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (kick)      cnt <= RELOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy   = kick || (cnt != '0);
  assign expire = !kick && (cnt == CW'(1));
endmodule

// File: rtl/pm_peak_hold.sv
module pm_peak_hold
  import pm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              clear,
  input  logic [SMP_W-1:0]  sample,
  output logic [PEAK_W-1:0] peak
);
  logic [PEAK_W-1:0] code;
  logic              bigger;

  assign code   = peak_code(sample);
  assign bigger = code > peak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 peak <= '0;
    else if (clear)             peak <= '0;
    else if (capture && bigger) peak <= code;
  end
endmodule

// File: rtl/pm_shift_out.sv
module pm_shift_out
  import pm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   sclk_rise,
  input  logic                   sclk_fall,
  input  logic                   abort,
  input  logic [NCH*PEAK_W-1:0]  par_in,
  output logic                   dout,
  output logic                   clr_all,
  output logic [$clog2(NCH*PEAK_W)-1:0] bit_cnt
);
  localparam int TOTAL = NCH * PEAK_W;
  localparam int BW    = $clog2(TOTAL);
  localparam logic [BW-1:0] LAST = BW'(TOTAL - 1);

  logic [TOTAL-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (load)      shreg <= par_in;
    else if (sclk_fall) shreg <= {1'b0, shreg[TOTAL-1:1]};
  end

  assign clr_all = sclk_rise && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bit_cnt <= '0;
    else if (clr_all)   bit_cnt <= '0;
    else if (sclk_rise) bit_cnt <= bit_cnt + 1'b1;
    else if (abort)     bit_cnt <= '0;
  end

  assign dout = shreg[0];
endmodule

// File: rtl/peak_meter_serial.sv
module peak_meter_serial
  import pm_pkg::*;
#(
  parameter int IDLE_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        meter_en,
  input  logic        smp_valid,
  input  logic        smp_right,
  input  logic [15:0] smp_data,
  input  logic        ser_clk,
  input  logic        ser_latch,
  output logic        ser_dout
);
  localparam int BW = $clog2(NCH * PEAK_W);

  logic sclk_s, latch_s, sclk_d, latch_d;
  logic sclk_rise, sclk_fall, latch_rise, sclk_edge;
  logic busy, tmr_expire, clr_all, capture_ok;
  logic [BW-1:0] bit_cnt;
  logic [PEAK_W-1:0] peak_q [NCH];
  logic [PEAK_W-1:0] peak_l, peak_r;

  pm_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
    .clk(clk), .rst_n(rst_n), .d_async(ser_clk), .q(sclk_s));
  pm_sync #(.STAGES(SYNC_STAGES)) u_sync_lat (
    .clk(clk), .rst_n(rst_n), .d_async(ser_latch), .q(latch_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      latch_d <= 1'b0;
    end else begin
      sclk_d  <= sclk_s;
      latch_d <= latch_s;
    end
  end

  assign sclk_rise  = sclk_s && !sclk_d;
  assign sclk_fall  = !sclk_s && sclk_d;
  assign latch_rise = latch_s && !latch_d;
  assign sclk_edge  = sclk_rise || sclk_fall;

  pm_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .kick(sclk_edge),
    .busy(busy), .expire(tmr_expire));

  assign capture_ok = meter_en && smp_valid && !busy;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic sel;
    assign sel = (ch == 0) ? !smp_right : smp_right;
    pm_peak_hold u_hold (
      .clk(clk), .rst_n(rst_n),
      .capture(capture_ok && sel),
      .clear(clr_all),
      .sample(smp_data),
      .peak(peak_q[ch]));
  end

  assign peak_l = peak_q[0];
  assign peak_r = peak_q[1];

  pm_shift_out u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(latch_rise),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .abort(tmr_expire),
    .par_in({peak_r, peak_l}),
    .dout(ser_dout),
    .clr_all(clr_all),
    .bit_cnt(bit_cnt));
endmodule

// File: rtl/pm_checker.sv
module pm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       meter_en,
  input logic       busy,
  input logic       clr_all,
  input logic       tmr_expire,
  input logic       sclk_fall,
  input logic       latch_rise,
  input logic       ser_dout,
  input logic [3:0] bit_cnt,
  input logic [7:0] peak_l,
  input logic [7:0] peak_r
);
  // R2
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all |=> (peak_l >= $past(peak_l)) && (peak_r >= $past(peak_r)));

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (peak_l == 8'd0) && (peak_r == 8'd0));

  // R5
  busy_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr_all) |=> $stable(peak_l) && $stable(peak_r));

  // R6
  expire_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_expire |=> (bit_cnt == 4'd0));

  // R7
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!meter_en && !clr_all) |=> $stable(peak_l) && $stable(peak_r));

  // R3
  dout_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_fall && !latch_rise) |=> $stable(ser_dout));
endmodule

bind peak_meter_serial pm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .meter_en(meter_en), .busy(busy),
  .clr_all(clr_all), .tmr_expire(tmr_expire), .sclk_fall(sclk_fall),
  .latch_rise(latch_rise), .ser_dout(ser_dout), .bit_cnt(bit_cnt),
  .peak_l(peak_l), .peak_r(peak_r));

// File: tb/tb_peak_meter_serial.sv
`timescale 1ns/1ps
module tb_peak_meter_serial;
  localparam int IDLE = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic meter_en = 1'b0;
  logic smp_valid = 1'b0;
  logic smp_right = 1'b0;
  logic [15:0] smp_data = '0;
  logic ser_clk = 1'b0;
  logic ser_latch = 1'b0;
  logic ser_dout;

  int checks = 0;
  int errors = 0;
  logic [15:0] word;

  always #5 clk = ~clk;

  peak_meter_serial #(.IDLE_CYCLES(IDLE)) dut (
    .clk(clk), .rst_n(rst_n), .meter_en(meter_en),
    .smp_valid(smp_valid), .smp_right(smp_right), .smp_data(smp_data),
    .ser_clk(ser_clk), .ser_latch(ser_latch), .ser_dout(ser_dout));

  function automatic logic [7:0] ref_code(input logic [15:0] x);
    int v;
    v = $signed(x);
    if (v < 0) v = -v;
    if (v > 32767) v = 32767;
    return 8'(v / 128);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic right, input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_right = right; smp_data = d;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic wait_idle();
    wait_cyc(IDLE + 12);
  endtask

  task automatic sclk_pulse();
    ser_clk = 1'b1; wait_cyc(5);
    ser_clk = 1'b0; wait_cyc(6);
  endtask

  task automatic latch_pulse();
    ser_latch = 1'b1; wait_cyc(4);
    ser_latch = 1'b0; wait_cyc(6);
  endtask

  task automatic read_bits(input int nbits, output logic [15:0] w);
    w = '0;
    latch_pulse();
    for (int i = 0; i < nbits; i++) begin
      w[i] = ser_dout;
      sclk_pulse();
    end
  endtask

  task automatic full_read(output logic [15:0] w);
    read_bits(16, w);
    wait_idle();
  endtask

  task automatic t_reset();
    check("R8 dout after reset", ser_dout, 1'b0);
    full_read(word);
    check("R8 peaks after reset", word, 16'h0000);
  endtask

  task automatic t_basic();
    send(1'b0, 16'h1234);
    send(1'b0, 16'h0100);
    send(1'b1, 16'hD000);
    full_read(word);
    check("R2 left peak", word[7:0], ref_code(16'h1234));
    check("R1 right negative", word[15:8], ref_code(16'hD000));
    check("R3 literal order", word, 16'h6024);
    full_read(word);
    check("R4 cleared after full read", word, 16'h0000);
  endtask

  task automatic t_saturate();
    send(1'b0, 16'h8000);
    send(1'b1, 16'hFF80);
    full_read(word);
    check("R1 0x8000 saturates", word[7:0], 8'hFF);
    check("R1 small negative", word[15:8], 8'h01);
  endtask

  task automatic t_greater_only();
    send(1'b0, 16'h4000);
    send(1'b0, 16'h1000);
    send(1'b0, 16'hC100);
    full_read(word);
    check("R2 keeps larger", word[7:0], 8'h80);
    check("R2 other channel untouched", word[15:8], 8'h00);
  endtask

  task automatic t_disabled();
    meter_en = 1'b0;
    send(1'b0, 16'h7000);
    send(1'b1, 16'h7000);
    full_read(word);
    check("R7 ignored when disabled", word, 16'h0000);
    meter_en = 1'b1;
  endtask

  task automatic t_freeze();
    sclk_pulse();
    send(1'b0, 16'h3F00);
    wait_idle();
    full_read(word);
    check("R5 no capture while busy", word[7:0], 8'h00);
    send(1'b1, 16'h2A00);
    full_read(word);
    check("R5 capture resumes after idle", word[15:8], ref_code(16'h2A00));
  endtask

  task automatic t_interrupt();
    send(1'b0, 16'h2800);
    send(1'b1, 16'h0A00);
    read_bits(8, word);
    check("R3 partial left bits", word[7:0], 8'h50);
    wait_idle();
    full_read(word);
    check("R6 peaks kept after abort", word, 16'h1450);
    full_read(word);
    check("R6 count restarted, then cleared", word, 16'h0000);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    meter_en = 1'b1;
    t_basic();
    t_saturate();
    t_greater_only();
    t_disabled();
    t_freeze();
    t_interrupt();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule